// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Supervisor

This block decides whether a 10 Mb/s twisted-pair port has a live partner. It sees decoded incoming link-pulse strobes, the receive and transmit activity levels and an end-of-frame strobe. From these it keeps an acceptance window relative to the most recent valid event. It declares the link failed when that window closes with nothing seen. It drives a link-good status and a datapath enable, which gates transmit, receive and loopback. A failed link needs a proof of life, followed by a quiet period, before the datapath is enabled again.

All timing derives from a free-running prescaler that produces one tick every `TICK_US` microseconds, computed from `CLK_FREQ_HZ`. The window bounds and the outgoing pulse period are counted in ticks. The same block requests an outgoing link pulse whenever the transmitter has been quiet for one period. It keeps doing so regardless of link state. When `en_i` is low the supervision is bypassed: the link reads good, the datapath is enabled and no pulses are requested.

Top module: `link_integrity_mon`

## Requirements
- R1: While and after reset (with `en_i` high and no input activity) the block is in the failed state: `link_good_o`=0, `path_en_o`=0, `tx_pulse_o`=0.
- R2: While `en_i` is low, `link_good_o`=1 and `path_en_o`=1 and `tx_pulse_o` stays 0. Raising `en_i` resumes supervision from a freshly started window with the link good.
- R3: With the link good, a pulse strobe that arrives between OPEN_US and CLOSE_US after the last valid event restarts both window bounds, so the link stays good.
- R4: With the link good, a pulse strobe arriving less than OPEN_US after the last valid event is ignored and does not move the failure deadline.
- R5: With the link good, if CLOSE_US elapses after the last valid event with no in-window pulse and no receive activity, `link_good_o` and `path_en_o` both drop to 0, within one tick plus two clock cycles.
- R6: In the failed state, recovery by pulses needs two consecutive pulses whose spacing is at least OPEN_US and below CLOSE_US. A pulse that comes too soon or too late after the previous one becomes the new first pulse of the pair.
- R7: In the failed state, an end-of-frame strobe (a received packet) is a recovery event.
- R8: After a recovery event the block waits with `link_good_o`=1 and `path_en_o`=0 until both `tx_act_i` and `rx_act_i` are low. It then enables the datapath. `path_en_o`=1 never occurs with `link_good_o`=0.
- R9: While `tx_act_i` stays low, a pulse request starts every TX_US exactly. `tx_act_i` high suppresses requests and restarts the period count.
- R10: Each request holds `tx_pulse_o` high for PULSE_NS worth of clock cycles (at least one), and requests continue while the link is failed.
- R11: With the link good, receive activity or an end-of-frame strobe restarts the window regardless of when it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Supervision enable; low bypasses it |
| rx_pulse_i | input | 1 | One-cycle strobe per decoded incoming link pulse |
| rx_act_i | input | 1 | Receive traffic present |
| tx_act_i | input | 1 | Transmit traffic present |
| rx_frame_end_i | input | 1 | One-cycle strobe at the end of a received frame |
| link_good_o | output | 1 | Link status for the link indicator |
| path_en_o | output | 1 | Enable for transmit, receive and loopback |
| tx_pulse_o | output | 1 | Outgoing link-pulse level request |

## Verification
The bench builds the block with `CLK_FREQ_HZ`=100_000 and `TICK_US`=100 on a 100 MHz clock. That makes one tick every 10 cycles. The window then opens after 650 cycles and closes after 10 400 cycles, and the pulse period is 1600 cycles. At this scale failure deadlines, early-pulse rejection, both recovery paths and several transmit periods all fit in a short run. The pulse width collapses to one cycle. The bench avoids the one-tick phase uncertainty by sampling with margins around each bound. It checks the transmit period exactly, because that count restarts on its own ticks.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;
  typedef enum logic [1:0] {
    ST_FAIL = 2'd0,
    ST_WAIT = 2'd1,
    ST_OK   = 2'd2
  } lm_state_e;
endpackage

// File: rtl/lm_tick_gen.sv
module lm_tick_gen #(
  parameter int unsigned CYC_PER_TICK = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  p_tick_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/lm_window.sv
module lm_window #(
  parameter int unsigned OPEN_TICKS  = 65,
  parameter int unsigned CLOSE_TICKS = 1040
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic early_o,
  output logic open_o,
  output logic expired_o
);
  localparam int unsigned AW = $clog2(CLOSE_TICKS + 1);
  localparam logic [AW-1:0] OPEN_V  = AW'(OPEN_TICKS);
  localparam logic [AW-1:0] CLOSE_V = AW'(CLOSE_TICKS);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          age_q <= '0;
    else if (restart_i)                   age_q <= '0;
    else if (tick_i && age_q != CLOSE_V)  age_q <= age_q + 1'b1;
  end

  assign early_o   = (age_q < OPEN_V);
  assign open_o    = (age_q >= OPEN_V) && (age_q < CLOSE_V);
  assign expired_o = (age_q == CLOSE_V);

  p_age_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q <= CLOSE_V);
  p_restart_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> early_o);
endmodule

// File: rtl/lm_fsm.sv
module lm_fsm
  import link_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      rx_pulse_i,
  input  logic      rx_act_i,
  input  logic      tx_act_i,
  input  logic      rx_frame_end_i,
  input  logic      early_i,
  input  logic      open_i,
  input  logic      expired_i,
  output logic      restart_o,
  output lm_state_e state_o
);
  lm_state_e st_q, st_d;
  logic      armed_q, armed_d;

  always_comb begin
    st_d      = st_q;
    armed_d   = armed_q;
    restart_o = 1'b0;
    if (!en_i) begin
      st_d      = ST_OK;
      armed_d   = 1'b0;
      restart_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_OK: begin
          if (rx_act_i || rx_frame_end_i || (rx_pulse_i && open_i)) begin
            restart_o = 1'b1;  // R11, R3
          end else if (expired_i) begin
            st_d      = ST_FAIL;
            armed_d   = 1'b0;
            restart_o = 1'b1;
          end
        end
        ST_FAIL: begin
          if (rx_frame_end_i) begin
            st_d = ST_WAIT;
          end else if (rx_pulse_i) begin
            if (armed_q && open_i) begin
              st_d = ST_WAIT;
            end else begin
              armed_d   = 1'b1;  // this pulse starts a new pair
              restart_o = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!tx_act_i && !rx_act_i) begin
            st_d      = ST_OK;
            armed_d   = 1'b0;
            restart_o = 1'b1;
          end
        end
        default: st_d = ST_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FAIL;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  assign state_o = st_q;

  p_no_direct_recover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_FAIL) |=> (st_q != ST_OK || !$past(en_i)));
  p_wait_needs_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_WAIT && (tx_act_i || rx_act_i)) |=> (st_q == ST_WAIT));
  p_early_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_OK && rx_pulse_i && early_i && !rx_act_i && !rx_frame_end_i)
      |=> (st_q == ST_OK));
endmodule

// File: rtl/lm_tx_pulse.sv
module lm_tx_pulse #(
  parameter int unsigned PERIOD_TICKS = 160,
  parameter int unsigned WIDTH_CYC    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic tx_act_i,
  output logic pulse_o
);
  localparam int unsigned PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int unsigned WW = $clog2(WIDTH_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [WW-1:0] W_LOAD = WW'(WIDTH_CYC);

  logic [PW-1:0] per_q;
  logic [WW-1:0] wid_q;
  logic          fire;

  assign fire = en_i && !tx_act_i && tick_i && (per_q == P_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
    end else if (!en_i || tx_act_i) begin
      per_q <= '0;
    end else if (tick_i) begin
      per_q <= (per_q == P_LAST) ? '0 : per_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wid_q <= '0;
    else if (!en_i)         wid_q <= '0;
    else if (fire)          wid_q <= W_LOAD;
    else if (wid_q != '0)   wid_q <= wid_q - 1'b1;
  end

  assign pulse_o = (wid_q != '0);

  p_quiet_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> !$past(tx_act_i));
  p_width_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wid_q <= W_LOAD);
  p_off_when_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_o);
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
  import link_mon_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned TICK_US     = 100,
  parameter int unsigned OPEN_US     = 6_500,
  parameter int unsigned CLOSE_US    = 104_000,
  parameter int unsigned TX_US       = 16_000,
  parameter int unsigned PULSE_NS    = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rx_pulse_i,
  input  logic rx_act_i,
  input  logic tx_act_i,
  input  logic rx_frame_end_i,
  output logic link_good_o,
  output logic path_en_o,
  output logic tx_pulse_o
);
  localparam int unsigned CYC_RAW   = (CLK_FREQ_HZ / 1000) * TICK_US / 1000;
  localparam int unsigned CYC_TICK  = (CYC_RAW > 0) ? CYC_RAW : 1;
  localparam int unsigned OPEN_T    = OPEN_US / TICK_US;
  localparam int unsigned CLOSE_T   = CLOSE_US / TICK_US;
  localparam int unsigned TX_T      = (TX_US / TICK_US > 0) ? TX_US / TICK_US : 1;
  localparam int unsigned PW_RAW    = (CLK_FREQ_HZ / 1_000_000) * PULSE_NS / 1000;
  localparam int unsigned PULSE_CYC = (PW_RAW > 0) ? PW_RAW : 1;

  logic      tick;
  logic      restart, early, in_win, expired;
  lm_state_e state;

  lm_tick_gen #(.CYC_PER_TICK(CYC_TICK)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  lm_window #(.OPEN_TICKS(OPEN_T), .CLOSE_TICKS(CLOSE_T)) u_win (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(restart),
    .early_o(early), .open_o(in_win), .expired_o(expired)
  );

  lm_fsm u_fsm (
    .clk_i, .rst_ni, .en_i, .rx_pulse_i, .rx_act_i, .tx_act_i, .rx_frame_end_i,
    .early_i(early), .open_i(in_win), .expired_i(expired),
    .restart_o(restart), .state_o(state)
  );

  lm_tx_pulse #(.PERIOD_TICKS(TX_T), .WIDTH_CYC(PULSE_CYC)) u_txp (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .tx_act_i, .pulse_o(tx_pulse_o)
  );

  assign link_good_o = !en_i || (state != ST_FAIL);
  assign path_en_o   = !en_i || (state == ST_OK);

  p_path_needs_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_en_o |-> link_good_o);
  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (link_good_o && path_en_o));
endmodule

// File: tb/link_integrity_mon_test.sv
module link_integrity_mon_test;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int unsigned TCK_US = 100;
  localparam int CYC_TICK = 10;
  localparam int OPEN_C   = 650;
  localparam int CLOSE_C  = 10_400;
  localparam int TX_C     = 1600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, rx_pulse = 1'b0, rx_act = 1'b0, tx_act = 1'b0, frame_end = 1'b0;
  logic link_good, path_en, tx_pulse;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, last_rise = 0, prev_rise = 0, run = 0, last_width = 0;
  logic prev_p = 1'b0;

  always #5 clk = ~clk;

  link_integrity_mon #(.CLK_FREQ_HZ(CLK_HZ), .TICK_US(TCK_US)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rx_pulse_i(rx_pulse),
    .rx_act_i(rx_act), .tx_act_i(tx_act), .rx_frame_end_i(frame_end),
    .link_good_o(link_good), .path_en_o(path_en), .tx_pulse_o(tx_pulse)
  );

  function automatic int exp_width(int unsigned hz);
    int w = int'((hz / 1_000_000) * 100 / 1000);
    return (w > 0) ? w : 1;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_pulse && !prev_p) begin
      rises     <= rises + 1;
      prev_rise <= last_rise;
      last_rise <= cyc;
    end
    if (tx_pulse) run <= run + 1;
    else if (prev_p) begin last_width <= run; run <= 0; end
    prev_p <= tx_pulse;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in();
    rx_pulse = 1'b1; step(1); rx_pulse = 1'b0;
  endtask

  task automatic frame_in(input int len);
    rx_act = 1'b1; step(len); rx_act = 1'b0; frame_end = 1'b1; step(1); frame_end = 1'b0;
  endtask

  task automatic chk_state(input bit lg, input bit pe, input string tag);
    chk(link_good == lg, {tag, " link_good"}, link_good, lg);
    chk(path_en == pe, {tag, " path_en"}, path_en, pe);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0, e, gap, w;
    void'($urandom(32'd4242));
    step(3);
    chk_state(1'b0, 1'b0, "R1 in reset");
    chk(tx_pulse == 1'b0, "R1 tx_pulse", tx_pulse, 0);
    rst_n = 1'b1;
    step(20);
    chk_state(1'b0, 1'b0, "R1 after reset");

    // R6: spaced pair recovers
    pulse_in(); step(2000);
    chk_state(1'b0, 1'b0, "R6 after first pulse");
    pulse_in(); step(3);
    chk_state(1'b1, 1'b1, "R6 pair recovery");

    // R3/R11/R4: random traffic keeps link up
    for (int i = 0; i < 12; i++) begin
      gap = $urandom_range(800, 9500);
      e = 0;
      if ($urandom_range(0, 1) == 1) begin
        e = $urandom_range(30, 600);
        step(e); pulse_in();
      end
      step(gap - e);
      chk_state(1'b1, 1'b1, "R3 R4 link held by traffic");
      if ($urandom_range(0, 2) == 0) frame_in($urandom_range(2, 40));  // R11
      else pulse_in();
    end

    // R11: frame end very early after last event still restarts
    step(100); frame_in(5);
    step(CLOSE_C - 300);
    chk_state(1'b1, 1'b1, "R11 early frame restarts window");

    // R4/R5: early pulse ignored, failure relative to real event
    pulse_in(); r0 = cyc;
    step(OPEN_C - 50); pulse_in();
    step(CLOSE_C - 20 - (cyc - r0));
    chk_state(1'b1, 1'b1, "R4 R5 before deadline");
    w = rises;
    step(50);
    chk_state(1'b0, 1'b0, "R4 R5 failed at deadline");

    // R6: too-close pair does not recover, restarts pairing
    pulse_in(); step(300); pulse_in(); step(5);
    chk_state(1'b0, 1'b0, "R6 close pair ignored");
    step(2000); pulse_in(); step(3);
    chk_state(1'b1, 1'b1, "R6 recovery after re-pair");
    step(CLOSE_C + 100);
    chk_state(1'b0, 1'b0, "R5 second failure");

    // R6: pair too far apart
    pulse_in(); step(CLOSE_C + 200); pulse_in(); step(5);
    chk_state(1'b0, 1'b0, "R6 far pair ignored");
    step(1500); pulse_in(); step(3);
    chk_state(1'b1, 1'b1, "R6 recovery after far pair");
    step(CLOSE_C + 100);
    chk(rises - w >= 10, "R10 pulses during failure", rises - w, 10);

    // R7/R8: packet recovery with wait state
    chk_state(1'b0, 1'b0, "R5 failed before packet");
    tx_act = 1'b1;
    frame_in(20); step(2);
    chk_state(1'b1, 1'b0, "R7 R8 waiting");
    rx_act = 1'b1; tx_act = 1'b0; step(50);
    chk_state(1'b1, 1'b0, "R8 wait holds during rx");
    rx_act = 1'b0; step(3);
    chk_state(1'b1, 1'b1, "R7 R8 enabled when quiet");

    // R9/R10: period and width
    w = rises;
    while (rises < w + 2) step(1);
    step(20);
    chk(last_rise - prev_rise == TX_C, "R9 period", last_rise - prev_rise, TX_C);
    chk(last_width == exp_width(CLK_HZ), "R10 width", last_width, exp_width(CLK_HZ));
    tx_act = 1'b1; w = rises; step(3000);
    chk(rises == w, "R9 suppressed by tx", rises - w, 0);
    tx_act = 1'b0; r0 = cyc;
    while (rises == w && cyc - r0 < 4000) step(1);
    chk((last_rise - r0) >= TX_C - CYC_TICK - 5 && (last_rise - r0) <= TX_C + 5,
        "R9 restart after tx", last_rise - r0, TX_C);

    // R2: bypass
    step(CLOSE_C + 100);
    chk_state(1'b0, 1'b0, "R5 failed before bypass");
    en = 1'b0; step(2);
    chk_state(1'b1, 1'b1, "R2 bypass outputs");
    w = rises; step(CLOSE_C + 2000);
    chk(rises == w, "R2 no pulses when disabled", rises - w, 0);
    chk_state(1'b1, 1'b1, "R2 no failure when disabled");
    en = 1'b1; step(CLOSE_C - 300);
    chk_state(1'b1, 1'b1, "R2 fresh window after enable");
    step(400);
    chk_state(1'b0, 1'b0, "R2 R5 supervision resumed");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule